// File: doc/BRIEF.md
# Priority-Preemptive Virtual-Channel Link Arbiter

This block decides, on every flit cycle, which virtual channel drives the shared output link of one router output port. Each virtual channel carries packets of exactly one fixed priority level. Index 0 is the most urgent level and the highest index is the least urgent. Among the channels that present a flit and still hold downstream credit, the most urgent one wins. The winner can change between any two flits. A more urgent packet therefore takes the link away from a less urgent packet in the middle of that packet. The interrupted packet continues later from the flit where it stopped.

Flow control uses credits. Each channel has a counter that starts at the depth of the downstream buffer. The counter goes down by one for every flit sent and up by one for every credit pulse returned by the downstream router. A channel whose counter is zero takes no part in arbitration.

The grant is combinational and is returned to the input buffers as a per-channel pop strobe. The selected flit, its channel index and a valid flag leave the block one clock later, registered.

Top module: `vc_preempt_arbiter`

## Requirements
- R1: After reset `out_valid` is 0, and every credit counter holds `CREDIT_DEPTH`. From reset, each channel can therefore send `CREDIT_DEPTH` flits before any credit comes back.
- R2: A channel is eligible when its `vc_req` bit is 1 and its credit is non-zero. In every cycle `vc_pop` has bit i set only for the lowest-index eligible channel i.
- R3: `vc_pop` is all zero when no channel is eligible. At most one bit of `vc_pop` is ever set.
- R4: When channel i pops in a cycle, the next cycle shows `out_valid`=1, `out_vc`=i and `out_flit` equal to channel i's `vc_flit` slice (bits i*FLIT_W upward) from the popping cycle.
- R5: Each pop of channel i lowers its credit by one. After `CREDIT_DEPTH` pops with no credit returned, channel i is masked, even though it is the most urgent requester, and the next eligible channel wins instead.
- R6: A 1 on `credit_in[i]` raises channel i's credit by one. A pop and a credit return on the same channel in the same cycle leave its credit unchanged.
- R7: While a less urgent channel is part-way through a packet, a more urgent eligible requester takes the pop in that same cycle. The less urgent channel then sends nothing until no more urgent channel is eligible.
- R8: A preempted channel resumes with the flit it was holding, so its flit sequence arrives with nothing lost and nothing repeated.
- R9: In the cycle after a cycle with no pop, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vc_req | input | NUM_VC | Per channel: a flit is ready at the head of its input buffer |
| vc_flit | input | NUM_VC*FLIT_W | Head flit of each channel; channel i occupies bits i*FLIT_W upward |
| credit_in | input | NUM_VC | Per-channel credit-return pulse from downstream |
| vc_pop | output | NUM_VC | Combinational one-hot grant; removes the head flit of the granted channel |
| out_valid | output | 1 | Registered: a flit is on the link this cycle |
| out_vc | output | VC_W | Registered: channel index of the flit on the link |
| out_flit | output | FLIT_W | Registered: flit payload on the link |

## Verification
The assertions assume that downstream never returns more credits than were taken. In concrete terms, `credit_in[i]` is never 1 while channel i's counter is full and channel i is not popping. They also assume that each channel keeps its head flit stable until it is popped. The stimulus respects the first assumption in two ways. In the table walk, a credit is returned only in the cycle where that same channel pops. In the directed tests, credits are returned only after flits have been sent. The bench models each input buffer as a sequence counter that advances only on that channel's pop, which keeps the head flit stable until it is consumed.

// File: rtl/vc_preempt_arbiter.sv
module vc_preempt_arbiter #(
  parameter int NUM_VC       = 4,
  parameter int FLIT_W       = 16,
  parameter int CREDIT_DEPTH = 4,
  localparam int VC_W  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int CNT_W = $clog2(CREDIT_DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_VC-1:0]        vc_req,
  input  logic [NUM_VC*FLIT_W-1:0] vc_flit,
  input  logic [NUM_VC-1:0]        credit_in,
  output logic [NUM_VC-1:0]        vc_pop,
  output logic                     out_valid,
  output logic [VC_W-1:0]          out_vc,
  output logic [FLIT_W-1:0]        out_flit
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(CREDIT_DEPTH);

  logic [CNT_W-1:0]  credit [NUM_VC];
  logic [NUM_VC-1:0] eligible;
  logic [VC_W-1:0]   sel_vc;
  logic [FLIT_W-1:0] sel_flit;

  for (genvar i = 0; i < NUM_VC; i++) begin : g_vc
    assign eligible[i] = vc_req[i] && (credit[i] != '0);

    always_ff @(posedge clk) begin
      if (!rst_n) credit[i] <= FULL;
      else        credit[i] <= credit[i] - CNT_W'(vc_pop[i]) + CNT_W'(credit_in[i]);
    end

    a_r5_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
      credit[i] <= FULL);
    a_r6_no_excess_return: assert property (@(posedge clk) disable iff (!rst_n)
      (credit[i] == FULL && !vc_pop[i]) |-> !credit_in[i]);
    a_r4_link_matches_pop: assert property (@(posedge clk) disable iff (!rst_n)
      vc_pop[i] |=> (out_valid && out_vc == VC_W'(i)
                     && out_flit == $past(vc_flit[i*FLIT_W +: FLIT_W])));
    for (genvar j = 0; j < i; j++) begin : g_hi
      a_r7_preempt_lower: assert property (@(posedge clk) disable iff (!rst_n)
        (vc_req[j] && credit[j] != '0) |-> !vc_pop[i]);
    end
  end

  assign vc_pop = eligible & (~eligible + NUM_VC'(1));

  always_comb begin
    sel_vc   = '0;
    sel_flit = '0;
    for (int i = 0; i < NUM_VC; i++) begin
      if (vc_pop[i]) begin
        sel_vc   = VC_W'(i);
        sel_flit = vc_flit[i*FLIT_W +: FLIT_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_vc    <= '0;
      out_flit  <= '0;
    end else begin
      out_valid <= |vc_pop;
      out_vc    <= sel_vc;
      out_flit  <= sel_flit;
    end
  end

  a_r3_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vc_pop));
  a_r9_idle_link: assert property (@(posedge clk) disable iff (!rst_n)
    (vc_pop == '0) |=> !out_valid);

endmodule

// File: tb/sim_vc_preempt_arbiter.sv
`timescale 1ns/1ps
module sim_vc_preempt_arbiter;
  localparam int NV = 4;
  localparam int FW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NV-1:0]    vc_req = '0;
  logic [NV*FW-1:0] vc_flit;
  logic [NV-1:0]    credit_in = '0;
  logic [NV-1:0]    vc_pop;
  logic             out_valid;
  logic [1:0]       out_vc;
  logic [FW-1:0]    out_flit;

  int checks = 0;
  int failures = 0;
  logic [11:0] seq [NV];

  always #4 clk = ~clk;

  vc_preempt_arbiter #(.NUM_VC(NV), .FLIT_W(FW), .CREDIT_DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .vc_req(vc_req), .vc_flit(vc_flit),
    .credit_in(credit_in), .vc_pop(vc_pop), .out_valid(out_valid),
    .out_vc(out_vc), .out_flit(out_flit));

  function automatic logic [FW-1:0] mk(input int v, input logic [11:0] s);
    return {4'(v + 1), s};
  endfunction

  always_comb
    for (int v = 0; v < NV; v++) vc_flit[v*FW +: FW] = mk(v, seq[v]);

  always @(posedge clk)
    for (int v = 0; v < NV; v++)
      if (!rst_n) seq[v] <= '0;
      else if (vc_pop[v]) seq[v] <= seq[v] + 12'd1;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] req, input logic [3:0] ret,
                      input logic [3:0] exp_pop, input string tag);
    int ev;
    logic [FW-1:0] ef;
    @(negedge clk);
    vc_req = req;
    credit_in = ret;
    #1;
    chk(vc_pop, exp_pop, {tag, " pop"});
    ev = 0;
    for (int v = 0; v < NV; v++) if (exp_pop[v]) ev = v;
    ef = mk(ev, seq[ev]);
    @(posedge clk);
    #1;
    chk(out_valid, |exp_pop, {tag, " valid"});
    if (|exp_pop) begin
      chk(out_vc, ev, {tag, " vc"});
      chk(out_flit, ef, {tag, " flit"});
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    vc_req = '0;
    credit_in = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // {req, expected pop}; the credit return equals the expected pop
  localparam logic [7:0] TBL [10] = '{
    8'b0001_0001, 8'b0010_0010, 8'b0110_0010, 8'b1100_0100, 8'b1000_1000,
    8'b1111_0001, 8'b0000_0000, 8'b1010_0010, 8'b1110_0010, 8'b0101_0001};

  initial begin
    do_reset();
    #1;
    chk(out_valid, 0, "R1 reset valid");

    for (int k = 0; k < 10; k++)
      step(TBL[k][7:4], TBL[k][3:0], TBL[k][3:0], "R2 R4 table");

    do_reset();
    for (int k = 0; k < 4; k++) step(4'b0011, 4'b0000, 4'b0001, "R1 full credit vc0");
    for (int k = 0; k < 4; k++) step(4'b0011, 4'b0000, 4'b0010, "R5 vc0 masked");
    step(4'b0011, 4'b0000, 4'b0000, "R3 R9 no eligible");
    step(4'b0000, 4'b0001, 4'b0000, "R6 return vc0");
    step(4'b0011, 4'b0000, 4'b0001, "R6 vc0 one credit");
    step(4'b0011, 4'b0000, 4'b0000, "R6 vc0 spent");
    step(4'b0000, 4'b0010, 4'b0000, "R6 return vc1");
    step(4'b0000, 4'b0010, 4'b0000, "R6 return vc1");
    step(4'b0010, 4'b0010, 4'b0010, "R6 same-cycle send and return");
    step(4'b0010, 4'b0000, 4'b0010, "R6 vc1 two left");
    step(4'b0010, 4'b0000, 4'b0010, "R6 vc1 one left");
    step(4'b0010, 4'b0000, 4'b0000, "R6 vc1 exhausted");

    do_reset();
    step(4'b0100, 4'b0000, 4'b0100, "R7 low packet flit0");
    step(4'b0100, 4'b0000, 4'b0100, "R7 low packet flit1");
    step(4'b0101, 4'b0000, 4'b0001, "R7 preempt");
    step(4'b0101, 4'b0000, 4'b0001, "R7 preempt held");
    step(4'b0100, 4'b0000, 4'b0100, "R8 resume");
    chk(out_flit, mk(2, 12'd2), "R8 resumed flit index");

    @(negedge clk);
    vc_req = '0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule